// File: doc/BRIEF.md
# Two-Wire Register Slave with Command-Byte Pointer

This block is the serial front end of a small sensor register file. It watches a two-wire bus (clock and data, both sampled by a fast system clock) and answers one 7-bit slave address. The address is picked from three fixed values by a three-level strap, modelled as a 2-bit code. A fixed alert address is also answered, whatever the strap says. The block pulls the data line low through an open-drain enable whenever it acknowledges or sends a zero bit.

In a write, the first byte after the address may be a command byte, marked by a set top bit. Its low four bits load a register pointer. Every other written byte goes to the register the pointer names, and the pointer then steps on by one. Reads return the register at the pointer, most significant bit first, and step the pointer on the same way. Single-byte, word and block transfers all follow from these rules. So do combined reads, where a command write is followed by a repeated START and a read. The pointer survives STOP conditions, so a bare receive-byte transfer returns the register it names.

The register file sits outside the block. It is reached through an address, a write strobe with data, and a read strobe whose data must be valid in the same cycle.

Top module: `twowire_cmd_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) restarts address reception from any state, even in the middle of a byte. A rising SDA while SCL is high (STOP) returns the block to idle with SDA released.
- R2: The slave address is 0x29 for strap code 00, 0x39 for codes 01 and 11, and 0x49 for code 10. On a match, the slave pulls SDA low during the ninth clock of the address byte. Bit 0 of that byte is the direction bit, with 1 meaning read.
- R3: For an address that matches neither the strap address nor the alert address, no ACK is given. SDA stays released and no register access takes place until the next START.
- R4: Address 0x0C is acknowledged under every strap code. After it, no register is read or written, and later bytes in the same transfer are not acknowledged.
- R5: In a write, if the first byte after the address has bit 7 set, bits 3:0 are loaded into the pointer and no register is written. Every byte of an addressed write is acknowledged.
- R6: Every other byte of a write, including later bytes with bit 7 set, is written to the register at the pointer with a one-cycle write strobe. The pointer then increments, wrapping from 15 to 0.
- R7: In a read, each byte is the register at the pointer, sent MSB first. The pointer increments after each byte is fetched, so a block read returns consecutive registers and wraps from 15 to 0.
- R8: After a read byte, a master ACK (SDA low on the ninth clock) fetches the next byte. A master NACK releases SDA for the rest of the transfer, with no further register reads.
- R9: The pointer is kept across STOP. A read with no command in its transfer returns the register at the stored pointer.
- R10: A combined read returns the register just selected by the command: a command write, a repeated START, then a read address.
- R11: After reset, SDA is released, the pointer is 0 and neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 2 | Address strap code: 00 low, 01 floating, 10 high, 11 treated as floating |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| reg_addr | output | 4 | Register file address, equal to the pointer |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd_en | output | 1 | One-cycle read strobe; data is taken in the same cycle |
| reg_rdata | input | 8 | Read data for reg_addr |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser, 8-bit bytes and a 4-bit pointer. The pointer space is therefore only 16 entries, small enough that every pointer value is written and read back through a combined read, and the block transfers cross the 15-to-0 wrap. All four strap codes are swept against all three strap addresses, the alert address and a wrong address, so every acknowledge decision is covered.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } tws_state_e;

  localparam logic [1:0] STRAP_LOW   = 2'b00;
  localparam logic [1:0] STRAP_FLOAT = 2'b01;
  localparam logic [1:0] STRAP_HIGH  = 2'b10;

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;
    logic              prev_q;

    always_comb begin
      pipe_d = {pipe_q[STAGES-2:0], raw[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= '1;
        prev_q <= 1'b1;
      end else begin
        pipe_q <= pipe_d;
        prev_q <= pipe_q[STAGES-1];
      end
    end

    assign lvl[g]  = pipe_q[STAGES-1];
    assign prev[g] = prev_q;
  end

  assign sda_lvl   = lvl[1];
  assign scl_rise  = lvl[0] & ~prev[0];
  assign scl_fall  = ~lvl[0] & prev[0];
  assign start_det = lvl[0] & prev[0] & prev[1] & ~lvl[1];
  assign stop_det  = lvl[0] & prev[0] & ~prev[1] & lvl[1];

endmodule

// File: rtl/tws_addr_match.sv
module tws_addr_match
  import tws_pkg::*;
#(
  parameter logic [6:0] ADDR_LOW   = 7'h29,
  parameter logic [6:0] ADDR_FLOAT = 7'h39,
  parameter logic [6:0] ADDR_HIGH  = 7'h49,
  parameter logic [6:0] ADDR_ALERT = 7'h0C
) (
  input  logic [1:0] strap_i,
  input  logic [6:0] addr7,
  output logic       addr_hit,
  output logic       alert_hit
);

  logic [6:0] own_addr;

  always_comb begin
    case (strap_i)
      STRAP_LOW:  own_addr = ADDR_LOW;
      STRAP_HIGH: own_addr = ADDR_HIGH;
      default:    own_addr = ADDR_FLOAT;
    endcase
    addr_hit  = (addr7 == own_addr);
    alert_hit = (addr7 == ADDR_ALERT);
  end

endmodule

// File: rtl/tws_pointer.sv
module tws_pointer #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = load | inc;
    if (load) ptr_d = load_val;
    else      ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && ptr_q == {PTR_W{1'b1}}) |=> (ptr_q == '0)); // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(ptr_q)); // R9

endmodule

// File: rtl/tws_engine.sv
module tws_engine
  import tws_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_lvl,
  input  logic              addr_hit,
  input  logic              alert_hit,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] shreg,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic              ptr_load,
  output logic [PTR_W-1:0]  ptr_load_val,
  output logic              ptr_inc,
  output logic              sda_oe
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  tws_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              ack_q, ack_d;
  logic              first_q, first_d;
  logic              rd_q, rd_d;
  logic              alert_q, alert_d;
  logic              mnack_q, mnack_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    ack_d     = ack_q;
    first_d   = first_q;
    rd_d      = rd_q;
    alert_d   = alert_q;
    mnack_d   = mnack_q;
    reg_wr_en = 1'b0;
    reg_rd_en = 1'b0;
    ptr_load  = 1'b0;
    ptr_inc   = 1'b0;

    if (stop_det) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      ack_d   = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      ack_d   = 1'b0;
      first_d = 1'b1;
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            cnt_d = '0;
            if (addr_hit || alert_hit) begin
              ack_d   = 1'b1;
              rd_d    = sh_q[0];
              alert_d = alert_hit;
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            ack_d = 1'b0;
            cnt_d = '0;
            if (alert_q) begin
              state_d = ST_IGNORE;
            end else if (rd_q) begin
              reg_rd_en = 1'b1;
              ptr_inc   = 1'b1;
              sh_d      = rd_data;
              state_d   = ST_RD_BYTE;
            end else begin
              state_d = ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            cnt_d   = '0;
            ack_d   = 1'b1;
            first_d = 1'b0;
            state_d = ST_WR_ACK;
            if (first_q && sh_q[BYTE_W-1]) begin
              ptr_load = 1'b1;
            end else begin
              reg_wr_en = 1'b1;
              ptr_inc   = 1'b1;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            ack_d   = 1'b0;
            state_d = ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == CNT_FULL) begin
              cnt_d   = '0;
              state_d = ST_RD_ACK;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b1};
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mnack_d = sda_lvl;
          end else if (scl_fall) begin
            if (mnack_q) begin
              state_d = ST_IGNORE;
            end else begin
              reg_rd_en = 1'b1;
              ptr_inc   = 1'b1;
              sh_d      = rd_data;
              state_d   = ST_RD_BYTE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '1;
      ack_q   <= 1'b0;
      first_q <= 1'b0;
      rd_q    <= 1'b0;
      alert_q <= 1'b0;
      mnack_q <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ack_q   <= ack_d;
      first_q <= first_d;
      rd_q    <= rd_d;
      alert_q <= alert_d;
      mnack_q <= mnack_d;
    end
  end

  assign shreg        = sh_q;
  assign ptr_load_val = sh_q[PTR_W-1:0];
  assign sda_oe       = ack_q | ((state_q == ST_RD_BYTE) & ~sh_q[BYTE_W-1]);

  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state_q == ST_ADDR)); // R1
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !sda_oe)); // R1
  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> (!sda_oe && !reg_wr_en && !reg_rd_en)); // R3
  AST_WR_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> (state_q == ST_WR_ACK && sda_oe)); // R6
  AST_NACK_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACK && mnack_q && scl_fall && !start_det && !stop_det)
      |=> (state_q == ST_IGNORE)); // R8

endmodule

// File: rtl/twowire_cmd_slave.sv
module twowire_cmd_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter int         BYTE_W      = 8,
  parameter int         PTR_W       = 4,
  parameter logic [6:0] ADDR_LOW    = 7'h29,
  parameter logic [6:0] ADDR_FLOAT  = 7'h39,
  parameter logic [6:0] ADDR_HIGH   = 7'h49,
  parameter logic [6:0] ADDR_ALERT  = 7'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap_i,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic              reg_wr_en,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_rd_en,
  input  logic [BYTE_W-1:0] reg_rdata
);

  logic              rst_meta, rst_s;
  logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic              addr_hit, alert_hit;
  logic [BYTE_W-1:0] shreg;
  logic              ptr_load, ptr_inc;
  logic [PTR_W-1:0]  ptr_load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_s),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tws_addr_match #(
    .ADDR_LOW   (ADDR_LOW),
    .ADDR_FLOAT (ADDR_FLOAT),
    .ADDR_HIGH  (ADDR_HIGH),
    .ADDR_ALERT (ADDR_ALERT)
  ) u_match (
    .strap_i   (strap_i),
    .addr7     (shreg[BYTE_W-1:BYTE_W-7]),
    .addr_hit  (addr_hit),
    .alert_hit (alert_hit)
  );

  tws_engine #(.BYTE_W(BYTE_W), .PTR_W(PTR_W)) u_engine (
    .clk          (clk),
    .rst_n        (rst_s),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .sda_lvl      (sda_lvl),
    .addr_hit     (addr_hit),
    .alert_hit    (alert_hit),
    .rd_data      (reg_rdata),
    .shreg        (shreg),
    .reg_wr_en    (reg_wr_en),
    .reg_rd_en    (reg_rd_en),
    .ptr_load     (ptr_load),
    .ptr_load_val (ptr_load_val),
    .ptr_inc      (ptr_inc),
    .sda_oe       (sda_oe)
  );

  tws_pointer #(.PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_s),
    .load     (ptr_load),
    .load_val (ptr_load_val),
    .inc      (ptr_inc),
    .ptr      (reg_addr)
  );

  assign reg_wdata = shreg;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_s |-> (!sda_oe && !reg_wr_en && !reg_rd_en)); // R11

endmodule

// File: tb/twowire_cmd_slave_tb_top.sv
module twowire_cmd_slave_tb_top;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic [1:0] strap;
  logic       sda_oe;
  logic [3:0] reg_addr;
  logic       reg_wr_en, reg_rd_en;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [16];
  logic [7:0] exp_m [16];
  int         wr_cnt, rd_cnt;
  int         n_chk = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  wire sda_line = sda_m & ~sda_oe;

  twowire_cmd_slave dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .strap_i   (strap),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rd_en (reg_rd_en),
    .reg_rdata (reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
      wr_cnt <= 0;
      rd_cnt <= 0;
    end else begin
      if (reg_wr_en) begin
        mem[reg_addr] <= reg_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (reg_rd_en) rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic do_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(x);
    acked = ~x;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      b[i] = x;
    end
    bit_out(~mack);
  endtask

  // combined read of n bytes starting at register p
  task automatic comb_read(input logic [3:0] p, input int n, output logic [7:0] d0,
                           output logic [7:0] d1);
    logic a;
    logic [7:0] b;
    do_start();
    send_byte(8'h52, a);
    send_byte({4'h8, p}, a);
    do_start();
    send_byte(8'h53, a);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      if (k == 0) d0 = b;
      if (k == 1) d1 = b;
    end
    do_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic       a;
    logic [7:0] d0, d1;
    int         w0, r0;
    scl_m = 1'b1; sda_m = 1'b1; strap = 2'b00; rst_n = 1'b0;
    d0 = '0; d1 = '0;
    for (int i = 0; i < 16; i++) exp_m[i] = 8'h00;
    tick(5);
    check_eq("R11 sda_oe in reset", int'(sda_oe), 0);
    check_eq("R11 strobes in reset", int'(reg_wr_en | reg_rd_en), 0);
    rst_n = 1'b1;
    tick(6);
    check_eq("R11 pointer after reset", int'(reg_addr), 0);
    check_eq("R11 sda_oe after reset", int'(sda_oe), 0);

    // R2 R3 R4: strap x address sweep
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      for (int c = 0; c < 5; c++) begin
        logic [6:0] ad;
        int sel, want;
        case (c)
          0: ad = 7'h29;
          1: ad = 7'h39;
          2: ad = 7'h49;
          3: ad = 7'h0C;
          default: ad = 7'h2B;
        endcase
        sel  = (s == 0) ? 0 : (s == 2) ? 2 : 1;
        want = (c == 3 || c == sel) ? 1 : 0;
        w0 = wr_cnt; r0 = rd_cnt;
        do_start();
        send_byte({ad, 1'b0}, a);
        if (c == 3)             check_eq("R4 alert address ack", int'(a), want);
        else if (want == 1)     check_eq("R2 strap address ack", int'(a), want);
        else                    check_eq("R3 foreign address nack", int'(a), want);
        if (want == 0 || c == 3) begin
          send_byte(8'h35, a);
          if (c == 3) check_eq("R4 byte after alert nack", int'(a), 0);
          else        check_eq("R3 byte after foreign addr nack", int'(a), 0);
          check_eq(c == 3 ? "R4 no access after alert" : "R3 no access",
                   (wr_cnt - w0) + (rd_cnt - r0), 0);
        end
        do_stop();
        tick(4);
        check_eq("R1 sda released after stop", int'(sda_oe), 0);
      end
    end
    strap = 2'b00;

    // R5 R6: write one byte to each register
    for (int p = 0; p < 16; p++) begin
      logic [7:0] v;
      v = 8'((p * 29 + 7) & 255);
      w0 = wr_cnt;
      do_start();
      send_byte(8'h52, a);
      send_byte(8'h80 | 8'(p), a);
      check_eq("R5 command byte ack", int'(a), 1);
      check_eq("R5 command byte no write", wr_cnt - w0, 0);
      send_byte(v, a);
      do_stop();
      exp_m[p] = v;
      check_eq("R6 single write lands at pointer", int'(mem[p]), int'(v));
    end

    // R6 block write across wrap, later MSB-set bytes are data
    w0 = wr_cnt;
    do_start();
    send_byte(8'h52, a);
    send_byte(8'h8D, a);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'hF1 + 8'(k), a);
      exp_m[(13 + k) % 16] = 8'hF1 + 8'(k);
    end
    do_stop();
    check_eq("R6 block write count", wr_cnt - w0, 4);
    for (int k = 0; k < 4; k++)
      check_eq("R6 block write wrap data", int'(mem[(13 + k) % 16]),
               int'(exp_m[(13 + k) % 16]));

    // R10 R7: combined read of every register
    for (int p = 0; p < 16; p++) begin
      comb_read(4'(p), 1, d0, d1);
      check_eq("R10 combined read", int'(d0), int'(exp_m[p]));
    end

    // R9: pointer kept across STOP (now 0 after wrap)
    do_start(); send_byte(8'h53, a); recv_byte(1'b0, d0); do_stop();
    check_eq("R9 receive byte after stop", int'(d0), int'(exp_m[0]));
    do_start(); send_byte(8'h53, a); recv_byte(1'b0, d0); do_stop();
    check_eq("R9 receive byte advances", int'(d0), int'(exp_m[1]));

    // R7 R8: block read across wrap, then NACK
    r0 = rd_cnt;
    do_start();
    send_byte(8'h52, a);
    send_byte(8'h8E, a);
    do_start();
    send_byte(8'h53, a);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k < 3, d0);
      check_eq("R7 block read wrap", int'(d0), int'(exp_m[(14 + k) % 16]));
    end
    check_eq("R8 reads before nack", rd_cnt - r0, 4);
    recv_byte(1'b0, d0);
    check_eq("R8 sda released after nack", int'(d0), 255);
    check_eq("R8 no read after nack", rd_cnt - r0, 4);
    do_stop();

    // R5 R9: send-byte command then receive-byte
    do_start(); send_byte(8'h52, a); send_byte(8'h83, a); do_stop();
    do_start(); send_byte(8'h53, a); recv_byte(1'b0, d0); do_stop();
    check_eq("R5 send byte sets pointer", int'(d0), int'(exp_m[3]));

    // R6 R7: write word then read word
    do_start(); send_byte(8'h52, a); send_byte(8'h85, a);
    send_byte(8'h11, a); send_byte(8'h22, a); do_stop();
    exp_m[5] = 8'h11; exp_m[6] = 8'h22;
    comb_read(4'h5, 2, d0, d1);
    check_eq("R7 read word low", int'(d0), 8'h11);
    check_eq("R7 read word high", int'(d1), 8'h22);

    // R1: START in the middle of a byte restarts addressing (pointer now 7)
    do_start();
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    do_start();
    send_byte(8'h53, a);
    check_eq("R1 restart mid byte ack", int'(a), 1);
    recv_byte(1'b0, d0);
    do_stop();
    check_eq("R1 read after restart", int'(d0), int'(exp_m[7]));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule